// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block keeps a set of four alarm bytes (seconds, minutes, hours and day of month) and compares them with the BCD fields of a running calendar clock. The clock counters themselves are outside the block. They supply their current field values and a one-cycle pulse each time the seconds advance. On each such pulse, every alarm field that is not masked is compared with its clock field. When all of them are equal, an alarm flag is set. An active-low interrupt line follows that flag while the alarm is enabled.

The alarm bytes, a control byte and a flags byte sit in a small byte-wide register window. The host reaches this window through the same write/read strobes it uses for the clock bytes. Bit 7 of each alarm byte removes that field from the comparison. This gives repeat rates of once per second, once per minute, once per hour or once per day. Reading the flags byte returns the flag and clears it, which releases the interrupt line.

A two-state machine holds the flag. In `ST_WATCH` no alarm is pending. On a hit it takes the transition `T_HIT` to `ST_FLAGGED`. A read of the flags byte with no new hit in the same cycle takes the transition `T_ACK` back to `ST_WATCH`. In all other cycles the state holds (`T_STAY`).

Top module: `alarm_cmp`

## Requirements
- R1: After reset `irq_n` is 1, all alarm bytes and the control byte read 0x00, and the flags byte reads 0x00.
- R2: Offsets 2, 3, 4 and 5 hold the seconds, minutes, hours and date alarm bytes. Each is fully writable and reads back as written.
- R3: A read strobe with an address samples the selected byte into `rdata`, where it is visible after the next rising edge. Offsets other than 0 and 2 to 6 read 0x00.
- R4: On a cycle with `sec_tick`=1, the flag is set at that edge if, for every alarm byte with bit 7 = 0, its bits 6:0 equal bits 6:0 of the matching clock field.
- R5: An alarm byte with bit 7 = 1 takes no part in the comparison. With all four masked, every tick sets the flag.
- R6: Without `sec_tick`, equal fields never set the flag.
- R7: `irq_n` is 0 exactly while the flag is set and the enable bit (offset 6, bit 7) is 1. Otherwise it is 1.
- R8: Reading offset 0 returns the flag in bit 6 and clears it at that edge. If a hit occurs in the same cycle, the flag stays set.
- R9: Writes to offset 0 and to unmapped offsets change no state.
- R10: With the enable bit at 0, a hit still sets the flag, which reads back as 0x40 at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register window |
| rd_en | input | 1 | Read strobe for the register window |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse after the clock fields advance |
| cal_sec | input | 8 | Clock seconds, BCD |
| cal_min | input | 8 | Clock minutes, BCD |
| cal_hour | input | 8 | Clock hours, BCD |
| cal_date | input | 8 | Clock day of month, BCD |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse. They also assume that the clock fields are already stable with their new values in the cycle where the pulse appears. They further assume that only the flags read, a hit or the enable write can move the interrupt line. The bench drives every input one nanosecond after a rising edge and holds it for the whole cycle. It chooses clock and alarm values from a small set of BCD values, so that random ticks often produce full and partial matches. Reads, writes and ticks are sometimes placed in the same cycle, which exercises the case where a read and a hit coincide.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
    localparam int FIELDS   = 4;
    localparam int BYTE_W   = 8;
    localparam int MASK_BIT = 7;
    localparam int FLAG_BIT = 6;
    localparam int EN_BIT   = 7;

    typedef enum logic [0:0] {
        ST_WATCH   = 1'b0,
        ST_FLAGGED = 1'b1
    } alm_state_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ALM_BASE  = 2,
    parameter int FLAG_ADDR = 0,
    parameter int CTRL_ADDR = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     flag_in,
    output logic [FIELDS*BYTE_W-1:0] alm_q,
    output logic                     en_q,
    output logic [BYTE_W-1:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

    logic [FIELDS-1:0] sel;
    logic [BYTE_W-1:0] rd_mux;

    // one alarm byte per field, address ALM_BASE + index
    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign sel[i] = (addr == ADDR_W'(ALM_BASE + i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[i*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && sel[i])
                alm_q[i*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en && addr == A_CTRL)
            en_q <= wdata[EN_BIT];
    end

    always_comb begin
        rd_mux = '0;
        if (addr == A_FLAG)
            rd_mux[FLAG_BIT] = flag_in;
        else if (addr == A_CTRL)
            rd_mux[EN_BIT] = en_q;
        else
            for (int i = 0; i < FIELDS; i++)
                if (sel[i])
                    rd_mux = alm_q[i*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_cmp_pkg::*;
(
    input  logic                     tick,
    input  logic [FIELDS*BYTE_W-1:0] alm,
    input  logic [FIELDS*BYTE_W-1:0] cal,
    output logic                     hit
);
    localparam int CMP_W = MASK_BIT;

    logic [FIELDS-1:0] fld_ok;

    for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
        logic [BYTE_W-1:0] a_b;
        logic [BYTE_W-1:0] c_b;
        assign a_b       = alm[i*BYTE_W +: BYTE_W];
        assign c_b       = cal[i*BYTE_W +: BYTE_W];
        assign fld_ok[i] = a_b[MASK_BIT] || (a_b[CMP_W-1:0] == c_b[CMP_W-1:0]);
    end

    assign hit = tick && (&fld_ok);
endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
    import alarm_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_rd,
    input  logic en,
    output logic flagged,
    output logic irq_n
);
    alm_state_e state_q;
    alm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_WATCH;
        else
            state_q <= state_d;
    end

    // transitions: T_HIT, T_ACK, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH:   if (hit)      state_d = ST_FLAGGED;
            ST_FLAGGED: if (flag_rd && !hit) state_d = ST_WATCH;
            default:    state_d = ST_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        flagged = (state_q == ST_FLAGGED);
        irq_n   = !(flagged && en);
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ALM_BASE  = 2,
    parameter int FLAG_ADDR = 0,
    parameter int CTRL_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              sec_tick,
    input  logic [7:0]        cal_sec,
    input  logic [7:0]        cal_min,
    input  logic [7:0]        cal_hour,
    input  logic [7:0]        cal_date,
    output logic              irq_n
);
    logic [FIELDS*BYTE_W-1:0] alm_q;
    logic [FIELDS*BYTE_W-1:0] cal_v;
    logic                     en_q;
    logic                     hit;
    logic                     flagged;
    logic                     flag_rd;

    assign cal_v   = {cal_date, cal_hour, cal_min, cal_sec};
    assign flag_rd = rd_en && (addr == ADDR_W'(FLAG_ADDR));

    alarm_regs #(
        .ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE),
        .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .flag_in(flagged),
        .alm_q(alm_q), .en_q(en_q), .rdata(rdata)
    );

    alarm_match u_match (
        .tick(sec_tick), .alm(alm_q), .cal(cal_v), .hit(hit)
    );

    alarm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag_rd(flag_rd),
        .en(en_q), .flagged(flagged), .irq_n(irq_n)
    );
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              sec_tick,
    input logic              irq_n,
    input logic              flagged,
    input logic              en_q
);
    logic ack;
    assign ack = rd_en && (addr == ADDR_W'(FLAG_ADDR));

    p_set_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flagged) |-> $past(sec_tick));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !ack) |=> $stable(flagged));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !sec_tick) |=> !flagged);

    p_disabled_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> irq_n);

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(sec_tick) || $past(wr_en)));
endmodule

bind alarm_cmp alarm_cmp_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .sec_tick(sec_tick), .irq_n(irq_n), .flagged(flagged), .en_q(en_q)
);

// File: tb/sim_alarm_cmp.sv
`timescale 1ns/1ps
module sim_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, sec_tick = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] cal_sec = '0, cal_min = '0, cal_hour = '0, cal_date = '0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_alm [4];
    logic       m_en, m_flag;

    always #2 clk = ~clk;

    alarm_cmp u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .cal_sec(cal_sec),
        .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date), .irq_n(irq_n)
    );

    function automatic logic [7:0] exp_read(logic [3:0] a);
        if (a == 4'd0) return {1'b0, m_flag, 6'b0};
        if (a == 4'd6) return {m_en, 7'b0};
        if (a >= 4'd2 && a <= 4'd5) return m_alm[a-2];
        return 8'h00;
    endfunction

    function automatic bit exp_hit(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
        logic [7:0] c [4];
        c[0] = s; c[1] = m; c[2] = h; c[3] = d;
        for (int i = 0; i < 4; i++)
            if (!m_alm[i][7] && (m_alm[i][6:0] != c[i][6:0])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit wr, bit rd, logic [3:0] a, logic [7:0] d, bit tk,
                        logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dt,
                        string tag);
        logic [7:0] er;
        bit hit;
        wr_en = wr; rd_en = rd; addr = a; wdata = d; sec_tick = tk;
        cal_sec = s; cal_min = m; cal_hour = h; cal_date = dt;
        @(posedge clk);
        er  = exp_read(a);
        hit = tk && exp_hit(s, m, h, dt);
        if (hit) m_flag = 1'b1;
        else if (rd && a == 4'd0) m_flag = 1'b0;
        if (wr) begin
            if (a >= 4'd2 && a <= 4'd5) m_alm[a-2] = d;
            else if (a == 4'd6) m_en = d[7];
        end
        #1;
        check({tag, " irq_n (R7)"}, {7'b0, irq_n}, {7'b0, !(m_flag && m_en)});
        if (rd) check({tag, " rdata (R3)"}, rdata, er);
        wr_en = 0; rd_en = 0; sec_tick = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
        step(1, 0, a, d, 0, cal_sec, cal_min, cal_hour, cal_date, tag);
    endtask
    task automatic rd(logic [3:0] a, string tag);
        step(0, 1, a, 8'h00, 0, cal_sec, cal_min, cal_hour, cal_date, tag);
    endtask
    task automatic tick(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dt, string tag);
        step(0, 0, 4'd0, 8'h00, 1, s, m, h, dt, tag);
    endtask

    function automatic logic [7:0] pick_bcd();
        logic [7:0] v [6];
        v[0] = 8'h00; v[1] = 8'h08; v[2] = 8'h15; v[3] = 8'h21; v[4] = 8'h30; v[5] = 8'h59;
        return v[$urandom_range(0, 5)];
    endfunction

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
        m_en = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset values
        check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        for (int a = 0; a < 7; a++) rd(4'(a), "R1 reset read");

        // R2: alarm bytes read back; R3 unmapped read
        wr(4'd2, 8'h30, "R2"); wr(4'd3, 8'h15, "R2");
        wr(4'd4, 8'h08, "R2"); wr(4'd5, 8'h21, "R2");
        for (int a = 2; a < 6; a++) rd(4'(a), "R2 readback");
        rd(4'd9, "R3 unmapped");
        // R9: writes to flags byte and unmapped offsets ignored
        wr(4'd0, 8'hFF, "R9"); wr(4'd12, 8'hFF, "R9");
        rd(4'd0, "R9 flags"); rd(4'd12, "R9 unmapped");
        for (int a = 2; a < 7; a++) rd(4'(a), "R9 state");

        wr(4'd6, 8'h80, "R7 enable");
        // R6: equal fields without tick
        step(0, 0, 4'd0, 8'h00, 0, 8'h30, 8'h15, 8'h08, 8'h21, "R6 no tick");
        // R4: one field different
        tick(8'h30, 8'h15, 8'h09, 8'h21, "R4 mismatch");
        // R4: full match
        tick(8'h30, 8'h15, 8'h08, 8'h21, "R4 match");
        rd(4'd0, "R8 read flag");
        rd(4'd0, "R8 flag cleared");

        // R5: minute-rate alarm (date/hour/min masked)
        wr(4'd3, 8'h95, "R5"); wr(4'd4, 8'h88, "R5"); wr(4'd5, 8'hA1, "R5");
        tick(8'h30, 8'h59, 8'h00, 8'h01, "R5 masked match");
        // R8: read and hit in the same cycle keep the flag
        step(0, 1, 4'd0, 8'h00, 1, 8'h30, 8'h00, 8'h00, 8'h02, "R8 read+hit");
        rd(4'd0, "R8 still set");
        // R5: all masked fires on any tick
        wr(4'd2, 8'hB0, "R5 all masked");
        tick(8'h07, 8'h42, 8'h13, 8'h19, "R5 every tick");
        rd(4'd0, "R5 ack");

        // R10: disabled alarm still flags
        wr(4'd6, 8'h00, "R10 disable");
        tick(8'h11, 8'h22, 8'h05, 8'h04, "R10 hit");
        rd(4'd0, "R10 flag readable");
        rd(4'd0, "R10 cleared");

        // random mix
        for (int n = 0; n < 2000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 2)
                wr(4'($urandom_range(2, 5)), {1'($urandom_range(0, 1)), pick_bcd()[6:0]}, "rand R2");
            else if (op == 2)
                wr(4'd6, {1'($urandom_range(0, 1)), 7'($urandom)}, "rand R7");
            else if (op == 3)
                rd(4'($urandom_range(0, 15)), "rand R3");
            else
                step(0, ($urandom_range(0, 4) == 0), 4'd0, 8'h00, ($urandom_range(0, 3) != 0),
                     pick_bcd(), pick_bcd(), pick_bcd(), pick_bcd(), "rand R4");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule